// File: doc/BRIEF.md
# Long-Instruction Word Unpacker and Slot Issuer

The block sits between instruction fetch and the functional units of a statically scheduled processor. Each fetched word is 64 bits wide and contains a 4-bit prefix and up to three instructions. The prefix tells the block how many instructions the word carries and how long each one is. It also tells the block whether to issue the slots together or one at a time. The block cuts the payload into slots and presents each slot on its own issue port. Each port carries the instruction left-justified in a 60-bit lane, its length in bits, its 8-bit primary opcode and two small sub-opcode fields.

Fetch is a valid/ready handshake. A parallel word issues every slot on the cycle after it is accepted, and fetch stays ready. A serial word issues slot 0, then slot 1, then slot 2, one per cycle. Fetch-ready stays low until the cycle in which the last slot appears. A prefix with no legal layout raises a one-cycle reject flag and issues nothing. All issue outputs come from registers.

Control is a two-state machine. `ST_ACCEPT` waits for a word. `ST_SERIAL` walks through the remaining slots of a serial word. The named transitions are:
- T_IDLE: stay in `ST_ACCEPT` with no word.
- T_BURST: issue all slots of a parallel word.
- T_SINGLE: issue a one-slot serial word and stay in `ST_ACCEPT`.
- T_REJECT: flag an illegal prefix.
- T_ENTER_SERIAL: go from `ST_ACCEPT` to `ST_SERIAL` after slot 0 of a multi-slot serial word.
- T_STEP: stay in `ST_SERIAL` and advance one slot.
- T_LEAVE_SERIAL: return to `ST_ACCEPT` on the last slot.

Top module: `lw_unpack`

## Requirements
- R1: While reset is asserted and right after it, in_ready_o is 1, and slot_valid_o and illegal_o are 0.
- R2: Bit numbering runs from the most significant end: word bit 0 is in_data_i[63]. The prefix is word bits 0..3. Slot 0 begins at word bit 4, and each later slot begins right after the previous one. A slot's bits appear left-justified in its 60-bit lane, with instruction bit 0 on lane bit 59 and zeros below the slot's length. Lane p is slot_bits_o[60p+59:60p], and the 6-bit length field is slot_len_o[6p+5:6p].
- R3: Prefix bit 0 (in_data_i[63]) selects serial issue when 1. The remaining prefix bits in_data_i[62:60] form a layout code, giving slot lengths in slot order: 0 = {60}, 1 = {30,30}, 2 = {30,24}, 3 = {20,20,20}, 4 = {24,16,20}, 5 = {16,16,24}, 6 = {20,20}. Code 7 is illegal.
- R4: slot_opc_o[8p+7:8p] carries instruction bits 0..7 of slot p, with bit 0 as its MSB.
- R5: slot_ext_o[2p+1:2p] carries instruction bits 18..19 (bit 18 as MSB) when the slot length is 20 or more, and 0 otherwise. slot_xtra_o[2p+1:2p] carries bits 28..29 only for 30-bit slots, and 0 otherwise.
- R6: A legal parallel word accepted on edge N drives slot_valid_o high for slots 0..count-1 only after edge N, for exactly one cycle. in_ready_o stays 1.
- R7: A legal serial word accepted on edge N shows slot k alone, on port k, after edge N+k. in_ready_o is 0 after every edge from N up to but not including the edge of the last slot. Words offered while in_ready_o is 0 are neither taken nor allowed to disturb the outputs.
- R8: A word with layout code 7 drives illegal_o high for one cycle after acceptance, with slot_valid_o all 0.
- R9: A port whose valid is low drives 0 on its bits, length and opcode fields. No slot is issued without an accepted word or a pending serial slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Fetch word valid |
| in_data_i | input | 64 | Fetched long-instruction word |
| in_ready_o | output | 1 | Block can take a word this cycle |
| slot_valid_o | output | 3 | Per-port issue valid |
| slot_bits_o | output | 180 | Three left-justified 60-bit instruction lanes |
| slot_len_o | output | 18 | Three 6-bit slot lengths in bits |
| slot_opc_o | output | 24 | Three 8-bit primary opcodes |
| slot_ext_o | output | 6 | Three 2-bit extended opcodes (bits 18..19) |
| slot_xtra_o | output | 6 | Three 2-bit extra opcodes of 30-bit slots (bits 28..29) |
| illegal_o | output | 1 | One-cycle flag for an illegal prefix |

## Verification
A stuck or wrongly advanced serial step counter shows at the ports on the very next cycle. The wrong port goes valid, two ports go valid at once, or in_ready_o returns too early or too late, and a held word that was corrupted by a stray capture gives wrong lane bits on slots 1 and 2. A wrong layout entry or offset shows on the first issue cycle as a bad length, shifted lane bits or misplaced opcode fields. The bench therefore compares every port field on every cycle of every word against a bit-by-bit reference model.

// File: rtl/lw_unpack_pkg.sv
package lw_unpack_pkg;
    localparam int WORD_W      = 64;
    localparam int PFX_W       = 4;
    localparam int NSLOT       = 3;
    localparam int LEN_W       = 6;
    localparam int OPC_W       = 8;
    localparam int SUBOP_W     = 2;
    localparam int OFF_W       = $clog2(WORD_W) + 1;
    localparam int CNT_W       = $clog2(NSLOT + 1);
    localparam int LANE_W      = WORD_W - PFX_W;
    localparam int EXT_POS     = 18;
    localparam int EXT_MIN_LEN = 20;
    localparam int XTRA_POS    = 28;
    localparam int XTRA_LEN    = 30;

    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_SERIAL = 1'b1
    } issue_state_e;
endpackage

// File: rtl/lw_layout_decode.sv
module lw_layout_decode
    import lw_unpack_pkg::*;
#(
    parameter int P_PFX_W = PFX_W,
    parameter int P_NSLOT = NSLOT,
    parameter int P_LEN_W = LEN_W,
    parameter int P_OFF_W = OFF_W,
    parameter int P_CNT_W = CNT_W
) (
    input  logic [P_PFX_W-1:0]         prefix_i,
    output logic                       serial_o,
    output logic                       legal_o,
    output logic [P_CNT_W-1:0]         count_o,
    output logic [P_NSLOT*P_LEN_W-1:0] len_o,
    output logic [P_NSLOT*P_OFF_W-1:0] off_o
);
    localparam int CODE_W = P_PFX_W - 1;

    logic [CODE_W-1:0]  code;
    logic [P_LEN_W-1:0] len_a [P_NSLOT];
    logic [P_OFF_W-1:0] off_a [P_NSLOT];

    assign serial_o = prefix_i[P_PFX_W-1];
    assign code     = prefix_i[CODE_W-1:0];

    always_comb begin
        legal_o = 1'b1;
        count_o = '0;
        for (int i = 0; i < P_NSLOT; i++) len_a[i] = '0;
        unique case (code)
            CODE_W'(0): begin count_o = P_CNT_W'(1); len_a[0] = P_LEN_W'(60); end
            CODE_W'(1): begin count_o = P_CNT_W'(2); len_a[0] = P_LEN_W'(30); len_a[1] = P_LEN_W'(30); end
            CODE_W'(2): begin count_o = P_CNT_W'(2); len_a[0] = P_LEN_W'(30); len_a[1] = P_LEN_W'(24); end
            CODE_W'(3): begin
                count_o = P_CNT_W'(3);
                len_a[0] = P_LEN_W'(20); len_a[1] = P_LEN_W'(20); len_a[2] = P_LEN_W'(20);
            end
            CODE_W'(4): begin
                count_o = P_CNT_W'(3);
                len_a[0] = P_LEN_W'(24); len_a[1] = P_LEN_W'(16); len_a[2] = P_LEN_W'(20);
            end
            CODE_W'(5): begin
                count_o = P_CNT_W'(3);
                len_a[0] = P_LEN_W'(16); len_a[1] = P_LEN_W'(16); len_a[2] = P_LEN_W'(24);
            end
            CODE_W'(6): begin count_o = P_CNT_W'(2); len_a[0] = P_LEN_W'(20); len_a[1] = P_LEN_W'(20); end
            default:    legal_o = 1'b0;
        endcase
    end

    assign off_a[0] = P_OFF_W'(P_PFX_W);

    for (genvar g = 0; g < P_NSLOT; g++) begin : g_slot
        if (g > 0) begin : g_chain
            assign off_a[g] = off_a[g-1] + P_OFF_W'(len_a[g-1]);
        end
        assign len_o[g*P_LEN_W +: P_LEN_W] = len_a[g];
        assign off_o[g*P_OFF_W +: P_OFF_W] = off_a[g];
    end
endmodule

// File: rtl/lw_slot_extract.sv
module lw_slot_extract
    import lw_unpack_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_PFX_W  = PFX_W,
    parameter int P_LEN_W  = LEN_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_OPC_W  = OPC_W
) (
    input  logic [P_WORD_W-1:0] word_i,
    input  logic [P_OFF_W-1:0]  off_i,
    input  logic [P_LEN_W-1:0]  len_i,
    output logic [P_WORD_W-P_PFX_W-1:0] lane_o,
    output logic [P_OPC_W-1:0]  opc_o,
    output logic [SUBOP_W-1:0]  ext_o,
    output logic [SUBOP_W-1:0]  xtra_o
);
    localparam int L_W      = P_WORD_W - P_PFX_W;
    localparam int EXT_MSB  = L_W - 1 - EXT_POS;
    localparam int XTRA_MSB = L_W - 1 - XTRA_POS;

    logic [P_WORD_W-1:0] shifted;
    logic [L_W-1:0]      keep;

    // Move the slot to the top of the word, then drop bits past its length.
    assign shifted = word_i << off_i;
    assign keep    = ~({L_W{1'b1}} >> len_i);
    assign lane_o  = shifted[P_WORD_W-1 -: L_W] & keep;
    assign opc_o   = lane_o[L_W-1 -: P_OPC_W];
    assign ext_o   = (len_i >= P_LEN_W'(EXT_MIN_LEN)) ? lane_o[EXT_MSB -: SUBOP_W] : '0;
    assign xtra_o  = (len_i == P_LEN_W'(XTRA_LEN))    ? lane_o[XTRA_MSB -: SUBOP_W] : '0;
endmodule

// File: rtl/lw_unpack.sv
module lw_unpack
    import lw_unpack_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_PFX_W  = PFX_W,
    parameter int P_NSLOT  = NSLOT,
    parameter int P_LEN_W  = LEN_W,
    parameter int P_OPC_W  = OPC_W
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               in_valid_i,
    input  logic [P_WORD_W-1:0]                in_data_i,
    output logic                               in_ready_o,
    output logic [P_NSLOT-1:0]                 slot_valid_o,
    output logic [P_NSLOT*(P_WORD_W-P_PFX_W)-1:0] slot_bits_o,
    output logic [P_NSLOT*P_LEN_W-1:0]         slot_len_o,
    output logic [P_NSLOT*P_OPC_W-1:0]         slot_opc_o,
    output logic [P_NSLOT*SUBOP_W-1:0]         slot_ext_o,
    output logic [P_NSLOT*SUBOP_W-1:0]         slot_xtra_o,
    output logic                               illegal_o
);
    localparam int L_W   = P_WORD_W - P_PFX_W;
    localparam int O_W   = $clog2(P_WORD_W) + 1;
    localparam int C_W   = $clog2(P_NSLOT + 1);

    issue_state_e         state_q, state_d;
    logic [C_W-1:0]       step_q, step_d;
    logic [P_WORD_W-1:0]  hold_q;
    logic                 capture;
    logic [P_WORD_W-1:0]  src_word;

    logic                 dec_serial, dec_legal;
    logic [C_W-1:0]       dec_count;
    logic [P_NSLOT*P_LEN_W-1:0] dec_len;
    logic [P_NSLOT*O_W-1:0]     dec_off;

    logic [P_NSLOT-1:0]   par_mask, issue_mask;
    logic                 reject;

    logic [L_W-1:0]       x_lane [P_NSLOT];
    logic [P_OPC_W-1:0]   x_opc  [P_NSLOT];
    logic [SUBOP_W-1:0]   x_ext  [P_NSLOT];
    logic [SUBOP_W-1:0]   x_xtra [P_NSLOT];

    // A multi-slot serial word is decoded from the held copy while it drains.
    assign src_word   = (state_q == ST_SERIAL) ? hold_q : in_data_i;
    assign in_ready_o = (state_q == ST_ACCEPT);

    lw_layout_decode #(
        .P_PFX_W (P_PFX_W),
        .P_NSLOT (P_NSLOT),
        .P_LEN_W (P_LEN_W),
        .P_OFF_W (O_W),
        .P_CNT_W (C_W)
    ) layout_i (
        .prefix_i (src_word[P_WORD_W-1 -: P_PFX_W]),
        .serial_o (dec_serial),
        .legal_o  (dec_legal),
        .count_o  (dec_count),
        .len_o    (dec_len),
        .off_o    (dec_off)
    );

    for (genvar g = 0; g < P_NSLOT; g++) begin : g_lane
        lw_slot_extract #(
            .P_WORD_W (P_WORD_W),
            .P_PFX_W  (P_PFX_W),
            .P_LEN_W  (P_LEN_W),
            .P_OFF_W  (O_W),
            .P_OPC_W  (P_OPC_W)
        ) extract_i (
            .word_i (src_word),
            .off_i  (dec_off[g*O_W +: O_W]),
            .len_i  (dec_len[g*P_LEN_W +: P_LEN_W]),
            .lane_o (x_lane[g]),
            .opc_o  (x_opc[g]),
            .ext_o  (x_ext[g]),
            .xtra_o (x_xtra[g])
        );

        assign par_mask[g] = (C_W'(g) < dec_count);
    end

    // State register and serial hold copy.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_ACCEPT;
            step_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (capture) hold_q <= in_data_i;
        end
    end

    // Transition and issue selection.
    always_comb begin
        state_d    = state_q;
        step_d     = step_q;
        capture    = 1'b0;
        issue_mask = '0;
        reject     = 1'b0;
        unique case (state_q)
            ST_ACCEPT: begin
                if (in_valid_i) begin
                    if (!dec_legal) begin
                        reject = 1'b1;                        // T_REJECT
                    end else if (dec_serial) begin
                        issue_mask = P_NSLOT'(1);
                        if (dec_count > C_W'(1)) begin       // T_ENTER_SERIAL
                            state_d = ST_SERIAL;
                            step_d  = C_W'(1);
                            capture = 1'b1;
                        end                                   // else T_SINGLE
                    end else begin
                        issue_mask = par_mask;                // T_BURST
                    end
                end                                           // else T_IDLE
            end
            ST_SERIAL: begin
                issue_mask = P_NSLOT'(1) << step_q;
                if (step_q == dec_count - C_W'(1)) begin      // T_LEAVE_SERIAL
                    state_d = ST_ACCEPT;
                    step_d  = '0;
                end else begin                                // T_STEP
                    step_d  = step_q + C_W'(1);
                end
            end
            default: state_d = ST_ACCEPT;
        endcase
    end

    // Registered issue outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_valid_o <= '0;
            illegal_o    <= 1'b0;
        end else begin
            slot_valid_o <= issue_mask;
            illegal_o    <= reject;
        end
    end

    for (genvar g = 0; g < P_NSLOT; g++) begin : g_out
        always_ff @(posedge clk_i) begin
            if (!rst_ni || !issue_mask[g]) begin
                slot_bits_o[g*L_W +: L_W]         <= '0;
                slot_len_o[g*P_LEN_W +: P_LEN_W]  <= '0;
                slot_opc_o[g*P_OPC_W +: P_OPC_W]  <= '0;
                slot_ext_o[g*SUBOP_W +: SUBOP_W]  <= '0;
                slot_xtra_o[g*SUBOP_W +: SUBOP_W] <= '0;
            end else begin
                slot_bits_o[g*L_W +: L_W]         <= x_lane[g];
                slot_len_o[g*P_LEN_W +: P_LEN_W]  <= dec_len[g*P_LEN_W +: P_LEN_W];
                slot_opc_o[g*P_OPC_W +: P_OPC_W]  <= x_opc[g];
                slot_ext_o[g*SUBOP_W +: SUBOP_W]  <= x_ext[g];
                slot_xtra_o[g*SUBOP_W +: SUBOP_W] <= x_xtra[g];
            end
        end
    end
endmodule

// File: rtl/lw_unpack_chk.sv
module lw_unpack_chk
    import lw_unpack_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_PFX_W  = PFX_W,
    parameter int P_NSLOT  = NSLOT,
    parameter int P_LEN_W  = LEN_W,
    parameter int P_OPC_W  = OPC_W
) (
    input logic                               clk_i,
    input logic                               rst_ni,
    input logic                               in_valid_i,
    input logic                               in_ready_o,
    input logic [P_NSLOT-1:0]                 slot_valid_o,
    input logic [P_NSLOT*(P_WORD_W-P_PFX_W)-1:0] slot_bits_o,
    input logic [P_NSLOT*P_LEN_W-1:0]         slot_len_o,
    input logic [P_NSLOT*P_OPC_W-1:0]         slot_opc_o,
    input logic                               illegal_o
);
    localparam int L_W = P_WORD_W - P_PFX_W;

    assert_reject_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (slot_valid_o == '0));

    assert_reject_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> $past(in_valid_i && in_ready_o));

    assert_serial_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_ready_o |-> $onehot(slot_valid_o));

    assert_serial_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_ready_o && $past(!in_ready_o)) |=> in_ready_o);

    assert_parallel_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(in_valid_i && in_ready_o) && ($countones(slot_valid_o) > 1)) |-> in_ready_o);

    assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_valid_o != '0) |-> ($past(in_valid_i && in_ready_o) || $past(!in_ready_o)));

    for (genvar g = 0; g < P_NSLOT; g++) begin : g_idle
        assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !slot_valid_o[g] |-> ((slot_bits_o[g*L_W +: L_W] == '0) &&
                                  (slot_len_o[g*P_LEN_W +: P_LEN_W] == '0) &&
                                  (slot_opc_o[g*P_OPC_W +: P_OPC_W] == '0)));
    end
endmodule

bind lw_unpack lw_unpack_chk #(
    .P_WORD_W (P_WORD_W),
    .P_PFX_W  (P_PFX_W),
    .P_NSLOT  (P_NSLOT),
    .P_LEN_W  (P_LEN_W),
    .P_OPC_W  (P_OPC_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .slot_valid_o (slot_valid_o),
    .slot_bits_o  (slot_bits_o),
    .slot_len_o   (slot_len_o),
    .slot_opc_o   (slot_opc_o),
    .illegal_o    (illegal_o)
);

// File: tb/lw_unpack_tb_top.sv
module lw_unpack_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [63:0]  in_data;
    logic         in_ready;
    logic [2:0]   slot_valid;
    logic [179:0] slot_bits;
    logic [17:0]  slot_len;
    logic [23:0]  slot_opc;
    logic [5:0]   slot_ext;
    logic [5:0]   slot_xtra;
    logic         illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lw_unpack dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .in_valid_i   (in_valid),
        .in_data_i    (in_data),
        .in_ready_o   (in_ready),
        .slot_valid_o (slot_valid),
        .slot_bits_o  (slot_bits),
        .slot_len_o   (slot_len),
        .slot_opc_o   (slot_opc),
        .slot_ext_o   (slot_ext),
        .slot_xtra_o  (slot_xtra),
        .illegal_o    (illegal)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference layout table (R3).
    task automatic ref_layout(input logic [2:0] code, output bit legal, output int cnt,
                              output int lens [3]);
        legal = 1'b1;
        cnt   = 0;
        lens  = '{0, 0, 0};
        case (code)
            3'd0: begin cnt = 1; lens = '{60, 0, 0};   end
            3'd1: begin cnt = 2; lens = '{30, 30, 0};  end
            3'd2: begin cnt = 2; lens = '{30, 24, 0};  end
            3'd3: begin cnt = 3; lens = '{20, 20, 20}; end
            3'd4: begin cnt = 3; lens = '{24, 16, 20}; end
            3'd5: begin cnt = 3; lens = '{16, 16, 24}; end
            3'd6: begin cnt = 2; lens = '{20, 20, 0};  end
            default: legal = 1'b0;
        endcase
    endtask

    // Bit-by-bit lane reference (R2): word bit i is in_data[63-i].
    function automatic logic [59:0] ref_lane(logic [63:0] w, int off, int len);
        logic [59:0] r = '0;
        for (int j = 0; j < len; j++) r[59-j] = w[63-(off+j)];
        return r;
    endfunction

    task automatic check_step(logic [63:0] w, int k);
        bit legal; int cnt; int lens [3]; bit ser; int off; bit ev;
        logic [59:0] lane; logic [7:0] opc; logic [1:0] ext, xtra;
        ref_layout(w[62:60], legal, cnt, lens);
        ser = w[63];
        chk(ser ? "R7" : "R6", "in_ready", 64'(in_ready),
            64'(!(legal && ser && k < cnt - 1)));
        chk("R8", "illegal", 64'(illegal), 64'(!legal && k == 0));
        off = 4;
        for (int p = 0; p < 3; p++) begin
            if (!legal)   ev = 1'b0;
            else if (ser) ev = (p == k);
            else          ev = (p < cnt);
            chk(ser ? "R7" : "R6", $sformatf("valid[%0d] step %0d", p, k),
                64'(slot_valid[p]), 64'(ev));
            if (ev) begin
                lane = ref_lane(w, off, lens[p]);
                for (int j = 0; j < 8; j++) opc[7-j] = lane[59-j];
                ext  = (lens[p] >= 20) ? {lane[59-18], lane[59-19]} : 2'b00;
                xtra = (lens[p] == 30) ? {lane[59-28], lane[59-29]} : 2'b00;
                chk("R2", $sformatf("bits[%0d]", p), 64'(slot_bits[p*60 +: 60]), 64'(lane));
                chk("R3", $sformatf("len[%0d]", p), 64'(slot_len[p*6 +: 6]), 64'(lens[p]));
                chk("R4", $sformatf("opc[%0d]", p), 64'(slot_opc[p*8 +: 8]), 64'(opc));
                chk("R5", $sformatf("ext[%0d]", p), 64'(slot_ext[p*2 +: 2]), 64'(ext));
                chk("R5", $sformatf("xtra[%0d]", p), 64'(slot_xtra[p*2 +: 2]), 64'(xtra));
            end else begin
                chk("R9", $sformatf("idle fields[%0d]", p),
                    64'({slot_bits[p*60 +: 60] != 0, slot_len[p*6 +: 6], slot_opc[p*8 +: 8],
                         slot_ext[p*2 +: 2], slot_xtra[p*2 +: 2]}), 64'(0));
            end
            off += lens[p];
        end
    endtask

    task automatic send(logic [63:0] w);
        bit legal; int cnt; int lens [3]; int steps;
        @(negedge clk);
        chk("R9", "idle valid", 64'(slot_valid), 64'(0));
        chk("R9", "idle ready", 64'(in_ready), 64'(1));
        in_valid = 1'b1;
        in_data  = w;
        ref_layout(w[62:60], legal, cnt, lens);
        steps = (legal && w[63]) ? cnt : 1;
        for (int k = 0; k < steps; k++) begin
            @(negedge clk);
            if (k < steps - 1) begin
                in_valid = 1'b1;                          // R7: offered while not ready
                in_data  = {$urandom, $urandom};
            end else begin
                in_valid = 1'b0;
            end
            check_step(w, k);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1B2C3D4E));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset ready", 64'(in_ready), 64'(1));
        chk("R1", "reset valid", 64'(slot_valid), 64'(0));
        chk("R1", "reset illegal", 64'(illegal), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset ready", 64'(in_ready), 64'(1));
        chk("R1", "post-reset valid", 64'(slot_valid), 64'(0));

        // Directed: every layout code, both issue modes, several payloads.
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                send({1'(s), 3'(c), 60'h0FED_CBA9_8765_432});
                send({1'(s), 3'(c), {60{1'b1}}});
                send({1'(s), 3'(c), {15{4'b1010}}});
                send({1'(s), 3'(c), 60'h0});
            end
        end
        // Single isolated set bits at slot edges.
        for (int b = 0; b < 60; b += 7) send({4'b1101, 60'(1) << b});

        // Constrained random: any prefix, any payload.
        for (int n = 0; n < 600; n++) send({$urandom, $urandom});

        repeat (2) @(negedge clk);
        chk("R9", "final idle", 64'(slot_valid), 64'(0));
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule